// File: doc/BRIEF.md
# Addend-Driven PTP Time Counter

This block keeps a free-running hardware time base for precision time protocol work. Every clock cycle it adds a programmable 32-bit rate word into a 32-bit fractional accumulator. Each carry out of that accumulator advances a 64-bit time count by one. One count stands for 32 ns, so nanoseconds are the count shifted left by five. Trimming the rate word around its reset value speeds the clock up or slows it down. The intended trim range is about ±5 % (±50,000,000 parts per billion).

Software reaches the block through a plain 32-bit register port with a single-cycle write strobe and a combinational read path. The time count is split into a low and a high word.

- **Reads** are coherent when the low word is read first. That read snapshots the high word, and the later high-word read returns the snapshot.
- **Writes** are also low word first. The low word is parked, and the high-word write loads both halves into the counter on one edge.

A control bit holds the block in reset. A separately armed wrap limit lets the low word roll over early. It is armed by setting the arm bit, writing the limit, then clearing the arm bit. With the arm bit clear, the counter runs as a full 64-bit count.

Top module: `ptp_time_counter`

## Requirements
- R1: After `rst_n` is released the time count is 0, the rate word (offset 1) reads 0xA0000000, the wrap limit (offset 5) reads 0xFFFFFFFF and the arm bit (offset 4, bit 0) reads 0.
- R2: Each cycle the rate word is added to a 32-bit accumulator and a carry out advances the time count by one. Starting from a cleared accumulator, after N cycles the count equals floor(N × rate / 2^32).
- R3: A read of offset 2 returns the current low time word and captures the high word into a shadow. A read of offset 3 returns that shadow, not the live high word.
- R4: A write to offset 2 leaves the running count untouched. A following write to offset 3 loads {high data, parked low} into the count at that edge, discarding any carry in that cycle.
- R5: While bit 0 of the control register (offset 0) is 1, the accumulator and the time count are held at 0 and no carry is reported. Time writes are ignored and the parked low word and the shadow are cleared. Clearing the bit resumes counting.
- R6: With the arm bit clear, the count behaves as one 64-bit counter, so a carry out of the low word increments the high word.
- R7: With the arm bit set, a carry that finds the low word at or above the wrap limit sets the low word to 0 and increments the high word.
- R8: Writes to the wrap limit are accepted only while the arm bit is 1; with the arm bit clear they leave the limit unchanged.
- R9: The rate word is read and written at offset 1. The control-register reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| time_o | output | 64 | Live time count in 32 ns units |
| tick_o | output | 1 | Accumulator carry: the count advances at this edge unless loaded |

## Verification
The checker assumes the two bus strobes are never raised together and that each strobe lasts exactly one cycle per access. It also assumes the low word is read before the high word whenever coherence matters. The bench drives every access from a negative edge, holds each for one rising edge only, and never overlaps a read with a write. Before every exact-count check it freezes the accumulator: it writes a rate of zero and then pulses the control reset. This puts the first carry at a known edge.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int WORD_W = 32;
  localparam int TIME_W = 2 * WORD_W;

  // Register offsets; the bench and software rely on these values.
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_RATE  = 3'd1,
    REG_TLO   = 3'd2,
    REG_THI   = 3'd3,
    REG_ARM   = 3'd4,
    REG_LIMIT = 3'd5
  } reg_sel_e;

  // One accumulator step: bit WORD_W of the result is the carry.
  function automatic logic [WORD_W:0] acc_add(input logic [WORD_W-1:0] acc,
                                              input logic [WORD_W-1:0] rate);
    return {1'b0, acc} + {1'b0, rate};
  endfunction

  // Time count after one carry, honouring the optional low-word limit.
  function automatic logic [TIME_W-1:0] time_step(input logic [TIME_W-1:0] t,
                                                  input logic              armed,
                                                  input logic [WORD_W-1:0] lim);
    logic [TIME_W-1:0] r;
    if (armed && (t[WORD_W-1:0] >= lim))
      r = {t[TIME_W-1:WORD_W] + 1'b1, {WORD_W{1'b0}}};
    else
      r = t + 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/ptp_rate_accum.sv
module ptp_rate_accum
  import ptp_tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [WORD_W-1:0] rate,
  output logic              tick
);

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W:0]   sum;

  assign sum  = acc_add(acc_q, rate);
  assign tick = sum[WORD_W] & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= sum[WORD_W-1:0];
  end

endmodule

// File: rtl/ptp_time_count.sv
module ptp_time_count
  import ptp_tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  input  logic              armed,
  input  logic [WORD_W-1:0] limit,
  output logic [TIME_W-1:0] time_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    time_q <= '0;
    else if (clr)  time_q <= '0;
    else if (load) time_q <= load_val;
    else if (tick) time_q <= time_step(time_q, armed, limit);
  end

endmodule

// File: rtl/ptp_reg_if.sv
module ptp_reg_if
  import ptp_tc_pkg::*;
#(
  parameter int                ADDR_W     = 3,
  parameter logic [WORD_W-1:0] RATE_RST   = 32'hA000_0000,
  parameter logic [WORD_W-1:0] LIMIT_RST  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [TIME_W-1:0] time_q,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] rate,
  output logic              blk_rst,
  output logic              armed,
  output logic [WORD_W-1:0] limit,
  output logic              load,
  output logic [TIME_W-1:0] load_val,
  output logic              rd_lo,
  output logic [WORD_W-1:0] shadow
);

  localparam int NREG = 2 ** ADDR_W;

  logic [NREG-1:0]   hit;
  logic [WORD_W-1:0] pend_lo_q;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit[i] = (bus_addr == ADDR_W'(i));
  end

  assign load     = bus_wr & hit[REG_THI] & ~blk_rst;
  assign load_val = {bus_wdata, pend_lo_q};
  assign rd_lo    = bus_rd & hit[REG_TLO] & ~blk_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_rst <= 1'b0;
      rate    <= RATE_RST;
      armed   <= 1'b0;
      limit   <= LIMIT_RST;
    end else if (bus_wr) begin
      if (hit[REG_CTRL])           blk_rst <= bus_wdata[0];
      if (hit[REG_RATE])           rate    <= bus_wdata;
      if (hit[REG_ARM])            armed   <= bus_wdata[0];
      if (hit[REG_LIMIT] && armed) limit   <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lo_q <= '0;
      shadow    <= '0;
    end else if (blk_rst) begin
      pend_lo_q <= '0;
      shadow    <= '0;
    end else begin
      if (bus_wr && hit[REG_TLO]) pend_lo_q <= bus_wdata;
      if (rd_lo)                  shadow    <= time_q[TIME_W-1:WORD_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit[REG_CTRL])  bus_rdata = {{(WORD_W-1){1'b0}}, blk_rst};
    if (hit[REG_RATE])  bus_rdata = rate;
    if (hit[REG_TLO])   bus_rdata = time_q[WORD_W-1:0];
    if (hit[REG_THI])   bus_rdata = shadow;
    if (hit[REG_ARM])   bus_rdata = {{(WORD_W-1){1'b0}}, armed};
    if (hit[REG_LIMIT]) bus_rdata = limit;
  end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int                ADDR_W    = 3,
  parameter logic [WORD_W-1:0] RATE_RST  = 32'hA000_0000,
  parameter logic [WORD_W-1:0] LIMIT_RST = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [TIME_W-1:0] time_o,
  output logic              tick_o
);

  // Internal events brought out by name for the bound checker.
  logic [WORD_W-1:0] rate_w;
  logic              blk_rst_w;
  logic              armed_w;
  logic [WORD_W-1:0] limit_w;
  logic              load_w;
  logic [TIME_W-1:0] load_val_w;
  logic              rd_lo_w;
  logic [WORD_W-1:0] shadow_w;
  logic              tick_w;

  ptp_reg_if #(
    .ADDR_W   (ADDR_W),
    .RATE_RST (RATE_RST),
    .LIMIT_RST(LIMIT_RST)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .time_q   (time_o),
    .bus_rdata(bus_rdata),
    .rate     (rate_w),
    .blk_rst  (blk_rst_w),
    .armed    (armed_w),
    .limit    (limit_w),
    .load     (load_w),
    .load_val (load_val_w),
    .rd_lo    (rd_lo_w),
    .shadow   (shadow_w)
  );

  ptp_rate_accum accum_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (blk_rst_w),
    .rate (rate_w),
    .tick (tick_w)
  );

  ptp_time_count count_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (blk_rst_w),
    .tick    (tick_w),
    .load    (load_w),
    .load_val(load_val_w),
    .armed   (armed_w),
    .limit   (limit_w),
    .time_q  (time_o)
  );

  assign tick_o = tick_w;

endmodule

// File: rtl/ptp_tc_checker.sv
module ptp_tc_checker
  import ptp_tc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              load,
  input logic [TIME_W-1:0] load_val,
  input logic              blk_rst,
  input logic              armed,
  input logic [WORD_W-1:0] limit,
  input logic [TIME_W-1:0] time_q,
  input logic              rd_lo,
  input logic [WORD_W-1:0] shadow
);

  AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rst |=> (time_q == '0)); // R5

  AST_NO_TICK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rst |-> !tick); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !blk_rst) |=> $stable(time_q)); // R2

  AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !blk_rst && !armed) |=> (time_q == $past(time_q) + 64'd1)); // R6

  AST_ARMED_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !blk_rst && armed && (time_q[WORD_W-1:0] >= limit))
    |=> (time_q[WORD_W-1:0] == '0)
        && (time_q[TIME_W-1:WORD_W] == $past(time_q[TIME_W-1:WORD_W]) + 1'b1)); // R7

  AST_PAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (time_q == $past(load_val))); // R4

  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (shadow == $past(time_q[TIME_W-1:WORD_W]))); // R3

endmodule

bind ptp_time_counter ptp_tc_checker chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .load    (load_w),
  .load_val(load_val_w),
  .blk_rst (blk_rst_w),
  .armed   (armed_w),
  .limit   (limit_w),
  .time_q  (time_o),
  .rd_lo   (rd_lo_w),
  .shadow  (shadow_w)
);

// File: tb/ptp_time_counter_tb_top.sv
module ptp_time_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {rate, cycles, expected count} from floor(cycles * rate / 2^32)
  localparam bit [95:0] VEC [0:NVEC-1] = '{
    {32'hA000_0000, 32'd8,  32'd5},
    {32'h8000_0000, 32'd10, 32'd5},
    {32'hFFFF_FFFF, 32'd20, 32'd19},
    {32'h4000_0000, 32'd13, 32'd3},
    {32'h0000_0000, 32'd30, 32'd0},
    {32'h1000_0000, 32'd50, 32'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] time_o;
  logic        tick_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_o(time_o), .tick_o(tick_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a negative edge and use one rising edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  // Rate 0, then control reset pulse: accumulator and count sit at zero.
  task automatic freeze();
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 time after reset", time_o, 64'h0);
    rd(3'd1, rd_val); chk("R1 rate reset", {32'h0, rd_val}, 64'hA000_0000);
    rd(3'd5, rd_val); chk("R1 limit reset", {32'h0, rd_val}, 64'hFFFF_FFFF);
    rd(3'd4, rd_val); chk("R1 arm reset", {32'h0, rd_val}, 64'h0);

    // R2 / R9: table of rates walked by one loop
    for (int i = 0; i < NVEC; i++) begin
      wr(3'd0, 32'h1);
      wr(3'd1, VEC[i][95:64]);
      wr(3'd0, 32'h0);
      edges(int'(VEC[i][63:32]));
      chk("R2 count after cycles", time_o, {32'h0, VEC[i][31:0]});
      rd(3'd1, rd_val);
      chk("R9 rate readback", {32'h0, rd_val}, {32'h0, VEC[i][95:64]});
    end

    // R3 and R6: coherent split read across a low-word carry
    freeze();
    wr(3'd2, 32'hFFFF_FFFE);
    wr(3'd3, 32'h7);
    wr(3'd1, 32'h8000_0000);
    rd(3'd2, rd_val);
    chk("R3 low word read", {32'h0, rd_val}, 64'hFFFF_FFFE);
    edges(4);
    chk("R6 64-bit carry", time_o, {32'h8, 32'h0});
    rd(3'd3, rd_val);
    chk("R3 high from shadow", {32'h0, rd_val}, 64'h7);

    // R4: parked low word, paired load
    freeze();
    wr(3'd2, 32'h1234);
    chk("R4 low write parked", time_o, 64'h0);
    wr(3'd3, 32'h55);
    chk("R4 paired load", time_o, {32'h55, 32'h1234});

    // R5: control reset holds count, blocks loads, clears parked low
    wr(3'd1, 32'hFFFF_FFFF);
    edges(5);
    wr(3'd2, 32'hABC);
    wr(3'd0, 32'h1);
    edges(3);
    chk("R5 count held", time_o, 64'h0);
    chk("R5 no carry", {63'h0, tick_o}, 64'h0);
    wr(3'd3, 32'h99);
    chk("R5 load ignored", time_o, 64'h0);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h2);
    chk("R5 parked low cleared", time_o, {32'h2, 32'h0});
    rd(3'd1, rd_val);
    chk("R9 rate kept over control reset", {32'h0, rd_val}, 64'h0);

    // R7: armed limit wrap
    wr(3'd4, 32'h1);
    wr(3'd5, 32'hF);
    freeze();
    wr(3'd2, 32'hE); wr(3'd3, 32'h0);
    wr(3'd1, 32'h8000_0000);
    edges(2);
    chk("R7 below limit", time_o, {32'h0, 32'hF});
    edges(2);
    chk("R7 wrap at limit", time_o, {32'h1, 32'h0});

    // R8: limit write ignored while disarmed
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h3);
    wr(3'd4, 32'h1);
    rd(3'd5, rd_val);
    chk("R8 limit unchanged", {32'h0, rd_val}, 64'hF);
    freeze();
    wr(3'd2, 32'hE); wr(3'd3, 32'h0);
    wr(3'd1, 32'h8000_0000);
    edges(2);
    chk("R8 old limit in force", time_o, {32'h0, 32'hF});

    // R6: disarmed ignores the limit
    wr(3'd4, 32'h0);
    freeze();
    wr(3'd2, 32'hE); wr(3'd3, 32'h0);
    wr(3'd1, 32'h8000_0000);
    edges(4);
    chk("R6 full count when disarmed", time_o, {32'h0, 32'h10});

    finish_run();
  end

endmodule